// File: doc/BRIEF.md
# Precision-Scalable Signed Multiplier

This block multiplies two 16-bit two's-complement operands and returns a 16-bit result. A mode pin selects the precision for each transfer. In full mode the result is the high half of the 32-bit signed product. In half mode only the high byte of each operand counts, and the result is the 16-bit signed product of those two bytes. It is meant for datapaths such as transform butterflies that can trade precision for switching energy from one operation to the next.

The array is split into four byte-sized tiles. Each tile sums its partial-product rows with sign bits inverted and a fixed correction constant added, which is the modified Baugh-Wooley method. The tiles are the high×high, high×low, low×high and low×low products. In half mode the low operand bytes are zeroed before the input register, so three tiles receive constant inputs and do not toggle. The cross-term adder and the upper combining adder are then skipped, and the high×high tile output goes straight to the result.

Both the input side and the output side are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. The input stage and the output stage each hold one operation. `in_ready` is high whenever the input stage is empty, the output stage is empty, or `out_ready` is high. The mode is captured together with its operands.

Top module: `pxmul`

## Requirements
- R1: With `in_half`=0, `out_prod` equals bits 31:16 of the signed 32-bit product of `in_a` and `in_b`.
- R2: With `in_half`=1, `out_prod` equals the signed 16-bit product of `in_a[15:8]` and `in_b[15:8]`.
- R3: With `in_half`=1, bits 7:0 of both operands have no effect on the result, and the three tiles that use them see all-zero inputs.
- R4: The mode is sampled with its operands. When consecutive transfers alternate modes, each result follows its own mode.
- R5: The most negative operands give correctly signed results. In full mode, 0x8000×0x8000 gives 0x4000 and 0x8000×0x7FFF gives 0xC000. In half mode, 0x80×0x80 gives 0x4000.
- R6: When the pipeline is empty and `out_ready` is high, a transfer accepted on clock edge k shows `out_valid`=0 after edge k and `out_valid`=1 after edge k+1.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_prod` hold their values on the next edge.
- R8: Results leave in the order they were accepted, with none lost or repeated. `in_ready` is low only when both stages are full and `out_ready` is low.
- R9: During and just after reset, `out_valid` is 0 and `in_ready` is 1.
- R10: A zero operand gives a zero result in either mode, and a zero input to any tile gives a zero tile output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Input stage can accept |
| in_a | input | 16 | Multiplicand, two's complement |
| in_b | input | 16 | Multiplier, two's complement |
| in_half | input | 1 | 1 = byte precision, 0 = full precision |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_prod | output | 16 | Signed result |

## Verification
The assertions check on every cycle that back-pressure holds data, that the three low tiles are idle in half mode, and that a zero operand gives a zero tile output. They also check that the sign of a half-mode result follows the operand signs and that an empty output stage keeps the input open. Only the bench scenarios can show that the numeric results are correct against an independent model. That includes the most negative corners, alternating modes in back-to-back transfers, ignored low bytes, result order under random stalls, and the exact latency.

// File: rtl/pxmul_pkg.sv
package pxmul_pkg;
  localparam int OP_W_DEF = 16;

  function automatic int half_of(input int w);
    return w / 2;
  endfunction
endpackage

// File: rtl/pxmul_stage.sv
module pxmul_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign up_ready = !v_q || dn_ready;
  assign dn_valid = v_q;
  assign dn_data  = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (up_ready) begin
      v_q <= up_valid;
      if (up_valid) d_q <= up_data;
    end
  end
endmodule

// File: rtl/pxmul_tile.sv
module pxmul_tile #(
  parameter int W        = 8,
  parameter int A_SIGNED = 1,
  parameter int B_SIGNED = 1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;
  localparam int NS = ((A_SIGNED != 0) ? 1 : 0) + ((B_SIGNED != 0) ? 1 : 0);
  localparam logic [PW-1:0] ONE  = 1;
  localparam logic [PW-1:0] CORR =
    (NS == 2) ? ((ONE << W) | (ONE << (PW - 1))) :
    (NS == 1) ? ((ONE << (PW - 1)) | (ONE << (W - 1))) : '0;

  function automatic logic flip(input int i, input int j);
    return ((A_SIGNED != 0) && (i == W - 1)) != ((B_SIGNED != 0) && (j == W - 1));
  endfunction

  logic [PW-1:0] row;
  logic [PW-1:0] acc;

  always_comb begin
    acc = CORR;
    row = '0;
    for (int j = 0; j < W; j++) begin
      row = '0;
      for (int i = 0; i < W; i++) begin
        row[i+j] = (a[i] & b[j]) ^ flip(i, j);
      end
      acc = acc + row;
    end
  end

  assign p = acc;

  always_comb begin
    if (a == '0 || b == '0) begin
      assert_zero_operand_R10: assert (p == '0);
    end
  end
endmodule

// File: rtl/pxmul_combine.sv
module pxmul_combine #(
  parameter int OP_W = 16
) (
  input  logic            half,
  input  logic [OP_W-1:0] hh,
  input  logic [OP_W-1:0] hl,
  input  logic [OP_W-1:0] lh,
  input  logic [OP_W-1:0] ll,
  output logic [OP_W-1:0] z
);
  localparam int H = OP_W / 2;

  logic [OP_W:0]   mid;
  logic [OP_W-1:0] mid_lo;
  logic [OP_W-1:0] mid_hi;
  logic            carry;
  logic [OP_W-1:0] upper;

  assign mid    = {hl[OP_W-1], hl} + {lh[OP_W-1], lh};
  assign mid_lo = {mid[H-1:0], {H{1'b0}}};
  assign mid_hi = {{(OP_W-H-1){mid[OP_W]}}, mid[OP_W:H]};
  assign carry  = 1'(({1'b0, mid_lo} + {1'b0, ll}) >> OP_W);
  assign upper  = hh + mid_hi + {{(OP_W-1){1'b0}}, carry};

  always_comb begin
    if (half) z = hh;
    else      z = upper;
  end
endmodule

// File: rtl/pxmul.sv
module pxmul #(
  parameter int OP_W = pxmul_pkg::OP_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_a,
  input  logic [OP_W-1:0] in_b,
  input  logic            in_half,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_prod
);
  localparam int H    = pxmul_pkg::half_of(OP_W);
  localparam int S1_W = 2 * OP_W + 1;

  logic [OP_W-1:0] a_g, b_g;
  logic [S1_W-1:0] s1_in, s1_q;
  logic            s1_valid, s1_ready;
  logic            s1_half;
  logic [OP_W-1:0] s1_a, s1_b;
  logic [OP_W-1:0] t_hh, t_hl, t_lh, t_ll;
  logic [OP_W-1:0] comb_z;

  // Gate the low bytes before the register so the low tiles stay quiet.
  assign a_g   = in_half ? {in_a[OP_W-1:H], {H{1'b0}}} : in_a;
  assign b_g   = in_half ? {in_b[OP_W-1:H], {H{1'b0}}} : in_b;
  assign s1_in = {in_half, a_g, b_g};

  pxmul_stage #(.W(S1_W)) u_in_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(s1_in),
    .dn_valid(s1_valid), .dn_ready(s1_ready), .dn_data(s1_q)
  );

  assign s1_half = s1_q[S1_W-1];
  assign s1_a    = s1_q[2*OP_W-1:OP_W];
  assign s1_b    = s1_q[OP_W-1:0];

  pxmul_tile #(.W(H), .A_SIGNED(1), .B_SIGNED(1)) u_hh (
    .a(s1_a[OP_W-1:H]), .b(s1_b[OP_W-1:H]), .p(t_hh));
  pxmul_tile #(.W(H), .A_SIGNED(1), .B_SIGNED(0)) u_hl (
    .a(s1_a[OP_W-1:H]), .b(s1_b[H-1:0]), .p(t_hl));
  pxmul_tile #(.W(H), .A_SIGNED(0), .B_SIGNED(1)) u_lh (
    .a(s1_a[H-1:0]), .b(s1_b[OP_W-1:H]), .p(t_lh));
  pxmul_tile #(.W(H), .A_SIGNED(0), .B_SIGNED(0)) u_ll (
    .a(s1_a[H-1:0]), .b(s1_b[H-1:0]), .p(t_ll));

  pxmul_combine #(.OP_W(OP_W)) u_combine (
    .half(s1_half), .hh(t_hh), .hl(t_hl), .lh(t_lh), .ll(t_ll), .z(comb_z));

  pxmul_stage #(.W(OP_W)) u_out_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s1_ready), .up_data(comb_z),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_prod)
  );

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_prod));
  assert_low_tiles_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_half |-> (t_hl == '0) && (t_lh == '0) && (t_ll == '0));
  assert_half_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_half && (s1_a[OP_W-1:H] != '0) && (s1_b[OP_W-1:H] != '0)
    |-> comb_z[OP_W-1] == (s1_a[OP_W-1] ^ s1_b[OP_W-1]));
  assert_open_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/pxmul_bench.sv
module pxmul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        in_half = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_prod;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int occ = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  bit hold_pend = 1'b0;
  logic [15:0] hold_val = '0;
  string cur_tag = "R1";
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pxmul u_pxmul (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_half(in_half),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic h);
    int p;
    if (h) begin
      p = int'($signed(a[15:8])) * int'($signed(b[15:8]));
      return p[15:0];
    end
    p = int'($signed(a)) * int'($signed(b));
    return p[31:16];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Reference model, run on every clock.
  always @(posedge clk) begin
    if (rst_n) begin
      logic [15:0] e;
      string t;
      if (hold_pend) chk(out_valid === 1'b1 && out_prod === hold_val, "R7", out_prod, hold_val);
      hold_pend = (out_valid === 1'b1) && (out_ready === 1'b0);
      hold_val  = out_prod;
      chk(in_ready === !(occ == 2 && !out_ready), "R8", {15'b0, in_ready}, 16'(!(occ == 2 && !out_ready)));
      if (occ == 0) chk(out_valid === 1'b0, "R8", {15'b0, out_valid}, 16'h0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", out_prod, 16'hxxxx);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_prod === e, t, out_prod, e);
        end
        occ--;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_a, in_b, in_half));
        tag_q.push_back(cur_tag);
        occ++;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    out_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 16'h0, 16'h0);
      report();
    end
  end

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic h,
                      input string tag);
    bit ok;
    in_valid = 1'b1; in_a = a; in_b = b; in_half = h; cur_tag = tag;
    forever begin
      #1 ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
  endtask

  task automatic idle_drain();
    in_valid = 1'b0;
    while (occ != 0 || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", {15'b0, out_valid}, 16'h0);
    chk(in_ready === 1'b1, "R9", {15'b0, in_ready}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9", {14'b0, out_valid, in_ready}, 16'h1);

    // R6: latency through an empty pipeline
    send(16'h1234, 16'h5678, 1'b0, "R1");
    in_valid = 1'b0;
    chk(out_valid === 1'b0, "R6", {15'b0, out_valid}, 16'h0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R6", {15'b0, out_valid}, 16'h1);
    idle_drain();

    // R1: full precision
    send(16'h7FFF, 16'h7FFF, 1'b0, "R1");
    send(16'hFFFF, 16'hFFFF, 1'b0, "R1");
    send(16'hC351, 16'h2A7B, 1'b0, "R1");
    send(16'h0100, 16'hFF00, 1'b0, "R1");
    // R10: zero operands
    send(16'h0000, 16'h8000, 1'b0, "R10");
    send(16'h9ABC, 16'h0000, 1'b0, "R10");
    send(16'h00FF, 16'h00FF, 1'b1, "R10");
    // R5: most negative values
    send(16'h8000, 16'h8000, 1'b0, "R5");
    send(16'h8000, 16'h7FFF, 1'b0, "R5");
    send(16'h8000, 16'h0001, 1'b0, "R5");
    send(16'h80A5, 16'h805A, 1'b1, "R5");
    send(16'h80FF, 16'h7F00, 1'b1, "R5");
    // R2, R3: byte precision with junk in the low bytes
    send(16'h7F00, 16'h7F00, 1'b1, "R2");
    send(16'hF3C7, 16'h1939, 1'b1, "R3");
    send(16'hF300, 16'h1900, 1'b1, "R3");
    send(16'h05FF, 16'hFBFF, 1'b1, "R3");
    // R4: alternating modes back to back
    for (int k = 0; k < 12; k++) begin
      send(16'($urandom), 16'($urandom), 1'(k % 2), "R4");
    end
    idle_drain();

    // R8 and R7: random traffic under random back-pressure
    bp_mode = 1'b1;
    for (int k = 0; k < 300; k++) begin
      send(16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)), "R8");
      if ($urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    bp_mode = 1'b0;
    idle_drain();
    chk(exp_q.size() == 0, "R8", 16'(exp_q.size()), 16'h0);
    report();
  end
endmodule